// File: doc/BRIEF.md
# Multi-Width Parallel Result Readout

This block holds an 18-bit conversion result and hands it to a host over a narrow parallel bus. A two-bit width selector picks a 16-bit bus, where the result is fetched as two words, or an 8-bit bus, where it is fetched as three bytes. The address lines choose which word or byte is placed on the bus. Chip-select and read are active-low strobes sampled on the system clock. The data bus is driven for one cycle after a sampled read and is high-impedance otherwise.

A small control machine tracks the converter. It moves from `CTL_IDLE` to `CTL_CONV` on a start pulse, which raises `busy`. It returns to `CTL_IDLE` on the converter's done pulse. The result register loads only on that return edge, so the host may read after a conversion or during the next one. During a conversion it sees the previous result, never a partly updated value.

The bus side has its own machine. It goes from `BUS_HIZ` to `BUS_DRIVE` when the strobes sampled on an edge form a read under a bus width it supports. It goes from `BUS_DRIVE` back to `BUS_HIZ` when they do not.

Top module: `par_result_readout`

## Requirements
- R1: While reset is asserted and just after it ends, `busy` is 0, `bus_oe` is 0, and the stored result is zero (a read returns zeros).
- R2: A `conv_start` pulse sampled in `CTL_IDLE` sets `busy` after that edge. A `conv_start` sampled while `busy` is 1 has no effect on `busy` or on the stored result.
- R3: A `conv_done` pulse sampled while `busy` is 1 clears `busy` after that edge. On the same edge it loads `conv_data` into the result register.
- R4: With `width_sel` = 1 (16-bit bus) and `addr[0]` = 0, the read returns result bits 17..2 on `bus_d[15:0]`. `addr[1]` is ignored in this mode.
- R5: With `width_sel` = 1 and `addr[0]` = 1, the read returns result bits 1..0 on `bus_d[15:14]`, with zeros on `bus_d[13:0]`.
- R6: With `width_sel` = 2 (8-bit bus), `bus_d[15:8]` is zero. On `bus_d[7:0]`, `addr` = 0 gives bits 17..10, `addr` = 1 gives bits 9..2, and `addr` = 2 gives bits 1..0 in positions 7..6 with zeros below.
- R7: With `width_sel` = 2 and `addr` = 3, the read drives all zeros.
- R8: `bus_oe` is 1, and `bus_d` is driven, exactly in the cycle after an edge at which `cs_n` and `rd_n` were both sampled low under a supported width. Otherwise the bus is high-impedance.
- R9: With `width_sel` = 0 or 3, a read never drives the bus.
- R10: A read taken while `busy` is 1 returns the result of the previous conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Start-of-conversion pulse |
| conv_done | input | 1 | Converter finished; `conv_data` valid |
| conv_data | input | 18 | Result from the converter |
| width_sel | input | 2 | Bus width: 1 = 16-bit, 2 = 8-bit, others no parallel bus |
| addr | input | 2 | Word/byte select |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| busy | output | 1 | Conversion in progress |
| bus_oe | output | 1 | High while the data bus is driven |
| bus_d | output | 16 | Tri-state data bus |

## Verification
The embedded assertions check the cycle-level rules on every clock. These are: the bus goes high-impedance after any edge without a valid read strobe, and is never driven under an unsupported width. The result register stays put throughout a conversion and loads the converter data on the edge where `busy` falls. The upper byte is zero on every 8-bit read. Only the bench scenarios can show the actual contents of each word and byte slice, the ignored start pulse during a conversion, and that a read during a conversion yields the earlier result rather than the new one.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

    typedef enum logic [1:0] {
        WSEL_NONE = 2'd0,
        WSEL_WORD = 2'd1,
        WSEL_BYTE = 2'd2,
        WSEL_SER  = 2'd3
    } wsel_t;

    typedef enum logic {
        CTL_IDLE = 1'b0,
        CTL_CONV = 1'b1
    } ctl_state_t;

    typedef enum logic {
        BUS_HIZ   = 1'b0,
        BUS_DRIVE = 1'b1
    } bus_state_t;

endpackage

// File: rtl/rdo_conv_ctrl.sv
module rdo_conv_ctrl
    import rdo_pkg::*;
#(
    parameter int RES_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             busy,
    output logic [RES_W-1:0] result_q
);

    ctl_state_t state_q, state_d;
    logic       load_en;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE: if (conv_start) state_d = CTL_CONV;
            CTL_CONV: if (conv_done)  state_d = CTL_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        busy    = (state_q == CTL_CONV);
        load_en = (state_q == CTL_CONV) && conv_done;
    end

    // Result holding register: updates only when busy falls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       result_q <= '0;
        else if (load_en) result_q <= conv_data;
    end

    // R3 / R10: result frozen while a conversion is still running
    p_hold_during_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> $stable(result_q));

    // R3: busy falls and data is captured on the done edge
    p_load_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> (!busy && result_q == $past(conv_data)));

    // R2: a start pulse from idle raises busy
    p_start_raises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && conv_start) |=> busy);

endmodule

// File: rtl/rdo_slice_sel.sv
module rdo_slice_sel
    import rdo_pkg::*;
#(
    parameter int RES_W  = 18,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  wsel_t            wsel,
    input  logic [1:0]       addr,
    output logic [BUS_W-1:0] slice,
    output logic             slice_ok
);

    localparam int WLO_W = RES_W - BUS_W;      // bits left for the low word
    localparam int BLO_W = RES_W - 2 * BYTE_W; // bits left for the low byte
    localparam int BPAD  = BUS_W - BYTE_W;     // unused upper lanes in byte mode

    logic [BUS_W-1:0]  word_hi, word_lo;
    logic [BYTE_W-1:0] byte_hi, byte_mid, byte_lo, byte_pick;

    always_comb begin
        word_hi  = result[RES_W-1 -: BUS_W];
        word_lo  = {result[WLO_W-1:0], {(BUS_W - WLO_W){1'b0}}};
        byte_hi  = result[RES_W-1 -: BYTE_W];
        byte_mid = result[RES_W-BYTE_W-1 -: BYTE_W];
        byte_lo  = {result[BLO_W-1:0], {(BYTE_W - BLO_W){1'b0}}};
    end

    always_comb begin
        unique case (addr)
            2'd0:    byte_pick = byte_hi;
            2'd1:    byte_pick = byte_mid;
            2'd2:    byte_pick = byte_lo;
            default: byte_pick = '0;
        endcase
    end

    always_comb begin
        slice    = '0;
        slice_ok = 1'b0;
        unique case (wsel)
            WSEL_WORD: begin
                slice    = addr[0] ? word_lo : word_hi;
                slice_ok = 1'b1;
            end
            WSEL_BYTE: begin
                slice    = {{BPAD{1'b0}}, byte_pick};
                slice_ok = 1'b1;
            end
            WSEL_NONE, WSEL_SER: begin
                slice    = '0;
                slice_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rdo_bus_port.sv
module rdo_bus_port
    import rdo_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  wsel_t            wsel,
    input  logic [BUS_W-1:0] slice,
    input  logic             slice_ok,
    output logic             bus_oe,
    output logic [BUS_W-1:0] bus_q
);

    bus_state_t       state_q, state_d;
    logic             rd_req;
    logic [BUS_W-1:0] data_q;

    always_comb begin
        rd_req  = !cs_n && !rd_n && slice_ok;
        state_d = state_q;
        unique case (state_q)
            BUS_HIZ:   if (rd_req)  state_d = BUS_DRIVE;
            BUS_DRIVE: if (!rd_req) state_d = BUS_HIZ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_HIZ;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      data_q <= '0;
        else if (rd_req) data_q <= slice;
    end

    always_comb begin
        bus_oe = (state_q == BUS_DRIVE);
        bus_q  = data_q;
    end

    // R8: no strobe pair on an edge means a released bus next cycle
    p_hiz_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |=> !bus_oe);

    // R9: unsupported widths never drive
    p_no_drive_bad_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wsel == WSEL_NONE || wsel == WSEL_SER) |=> !bus_oe);

    // R6: upper lanes are quiet on byte reads
    p_byte_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && wsel == WSEL_BYTE) |=> (bus_oe && bus_q[BUS_W-1:BYTE_W] == '0));

endmodule

// File: rtl/par_result_readout.sv
module par_result_readout
    import rdo_pkg::*;
#(
    parameter int RES_W  = 18,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             conv_start,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    input  logic [1:0]       width_sel,
    input  logic [1:0]       addr,
    input  logic             cs_n,
    input  logic             rd_n,
    output logic             busy,
    output logic             bus_oe,
    output logic [BUS_W-1:0] bus_d
);

    logic [RES_W-1:0] result_q;
    logic [BUS_W-1:0] slice, bus_q;
    logic             slice_ok;
    wsel_t            wsel;

    assign wsel = wsel_t'(width_sel);

    rdo_conv_ctrl #(.RES_W(RES_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .conv_done  (conv_done),
        .conv_data  (conv_data),
        .busy       (busy),
        .result_q   (result_q)
    );

    rdo_slice_sel #(.RES_W(RES_W), .BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_sel (
        .result   (result_q),
        .wsel     (wsel),
        .addr     (addr),
        .slice    (slice),
        .slice_ok (slice_ok)
    );

    rdo_bus_port #(.BUS_W(BUS_W), .BYTE_W(BYTE_W)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wsel     (wsel),
        .slice    (slice),
        .slice_ok (slice_ok),
        .bus_oe   (bus_oe),
        .bus_q    (bus_q)
    );

    assign bus_d = bus_oe ? bus_q : 'z;

endmodule

// File: tb/test_par_result_readout.sv
`timescale 1ns/1ps
module test_par_result_readout;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic        conv_done = 1'b0;
    logic [17:0] conv_data = '0;
    logic [1:0]  width_sel = 2'd0;
    logic [1:0]  addr = 2'd0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        busy, bus_oe;
    logic [15:0] bus_d;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    par_result_readout i_par_result_readout (
        .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .width_sel(width_sel), .addr(addr),
        .cs_n(cs_n), .rd_n(rd_n), .busy(busy), .bus_oe(bus_oe), .bus_d(bus_d)
    );

    // {width_sel, addr, expected oe, expected data} for result 18'h2D5A7
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {2'd1, 2'd0, 1'b1, 16'hB569},  // R4 high word
        {2'd1, 2'd2, 1'b1, 16'hB569},  // R4 addr[1] ignored
        {2'd1, 2'd1, 1'b1, 16'hC000},  // R5 low word
        {2'd1, 2'd3, 1'b1, 16'hC000},  // R5 addr[1] ignored
        {2'd2, 2'd0, 1'b1, 16'h00B5},  // R6 high byte
        {2'd2, 2'd1, 1'b1, 16'h0069},  // R6 middle byte
        {2'd2, 2'd2, 1'b1, 16'h00C0},  // R6 low byte
        {2'd2, 2'd3, 1'b1, 16'h0000},  // R7 unused address
        {2'd0, 2'd0, 1'b0, 16'h0000},  // R9 width 0
        {2'd3, 2'd1, 1'b0, 16'h0000}   // R9 width 3
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one read at a negedge, check at the following negedge, release
    task automatic do_read(input logic [1:0] w, input logic [1:0] a,
                           input logic exp_oe, input logic [15:0] exp_d, input string req);
        width_sel = w; addr = a; cs_n = 1'b0; rd_n = 1'b0;
        @(negedge clk);
        check({req, " oe"}, {31'd0, bus_oe}, {31'd0, exp_oe});
        if (exp_oe) check({req, " data"}, {16'd0, bus_d}, {16'd0, exp_d});
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        check({req, " release R8"}, {31'd0, bus_oe}, 32'd0);
    endtask

    task automatic convert(input logic [17:0] val);
        conv_start = 1'b1;
        @(negedge clk);
        conv_start = 1'b0;
        check("R2 busy rises", {31'd0, busy}, 32'd1);
        @(negedge clk);
        conv_data = val; conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        check("R3 busy falls", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        @(negedge clk);
        check("R1 busy in reset", {31'd0, busy}, 32'd0);
        check("R1 oe in reset", {31'd0, bus_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", {31'd0, busy}, 32'd0);
        do_read(2'd1, 2'd0, 1'b1, 16'h0000, "R1 zero result");

        // load the table's result
        convert(18'h2D5A7);

        for (int i = 0; i < NV; i++) begin
            do_read(VEC[i][20:19], VEC[i][18:17], VEC[i][16], VEC[i][15:0], "R4-table");
        end

        // R8: only cs_n low, or only rd_n low, never drives
        width_sel = 2'd1; addr = 2'd0; cs_n = 1'b0; rd_n = 1'b1;
        @(negedge clk);
        check("R8 cs only", {31'd0, bus_oe}, 32'd0);
        cs_n = 1'b1; rd_n = 1'b0;
        @(negedge clk);
        check("R8 rd only", {31'd0, bus_oe}, 32'd0);
        rd_n = 1'b1;

        // R10: read during next conversion sees old result; R2: extra start ignored
        conv_start = 1'b1;
        @(negedge clk);
        check("R2 busy set", {31'd0, busy}, 32'd1);
        conv_data = 18'h00003;   // new value presented but not yet done
        do_read(2'd1, 2'd0, 1'b1, 16'hB569, "R10 old high word");
        conv_start = 1'b0;
        check("R2 start in busy ignored", {31'd0, busy}, 32'd1);
        do_read(2'd2, 2'd2, 1'b1, 16'h00C0, "R10 old low byte");
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        check("R3 busy cleared", {31'd0, busy}, 32'd0);
        do_read(2'd1, 2'd0, 1'b1, 16'h0000, "R3 new high word");
        do_read(2'd1, 2'd1, 1'b1, 16'hC000, "R5 new low word");

        // R2: a start after the conversion ends begins a new one
        convert(18'h3FFFF);
        do_read(2'd2, 2'd1, 1'b1, 16'h00FF, "R6 all-ones middle byte");
        do_read(2'd1, 2'd0, 1'b1, 16'hFFFF, "R4 all-ones high word");

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule